// File: doc/BRIEF.md
# Display Panel Parallel Write Strobe Generator

This block drives an 8-bit parallel bus into a display panel that carries its own controller and frame memory. It holds one control word with three fields: a data byte, a counter preload and a strobe threshold. When software issues a command, a down counter loads the preload and counts one step per clock until it reaches zero. The panel strobe E is raised while the counter sits between the threshold and one. This gives the data set-up time before E rises and one clock of hold time after E falls.

A command selects either a write cycle or a read cycle. In a write cycle the data byte drives the pins. In a read cycle the pins are released, E follows the same window, and the bus value is captured into a read-data register on the final count. A global enable input gates cycle starts. The register-select and direction lines are not generated here; general-purpose outputs elsewhere provide them.

Top module: `spanel_strobe`

## Requirements
- R1: After reset, `busy`, `e_out` and `rd_data` are 0, `pd_out` is 0 and `pd_oe` is 1.
- R2: A command (`cmd_go` high at a rising edge) starts a cycle only if `if_en` is high and `busy` is low. With `if_en` low, `busy` stays 0.
- R3: An accepted command loads the counter with the preload P. `busy` then stays high for exactly P+1 cycles, starting the cycle after acceptance, with the counter stepping P, P-1, …, 0.
- R4: While busy, `e_out` is 1 exactly in the cycles where the counter value c satisfies 1 <= c <= S, given threshold S < P. Over one cycle E is therefore high for S clocks, and it is low during the zero count.
- R5: If S >= P, `e_out` never asserts during the cycle.
- R6: During a write cycle (`cmd_read`=0 at acceptance), `pd_oe` is 1 and `pd_out` carries the data byte through the zero count.
- R7: During a read cycle (`cmd_read`=1), `pd_oe` is 0 for every busy cycle and E follows the R4 window. `rd_data` takes the `pd_in` value present in the zero-count cycle and shows it from the next cycle onward.
- R8: Control-word writes (`cfg_we`) and commands presented while `busy` is high have no effect: the data byte, preload and threshold keep their values.
- R9: With `nibble_mode`=1, `pd_out[3:0]` carries data bits 3..0 and `pd_out[7:4]` is 0. With `nibble_mode`=0, data bit n drives `pd_out[n]`.
- R10: While `busy` is low, `e_out` is 0 and `pd_out` holds the last written data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Global parallel-interface enable |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_data | input | 8 | Data byte field |
| cfg_preload | input | 8 | Counter preload field |
| cfg_start | input | 8 | Strobe threshold field |
| cmd_go | input | 1 | Start a cycle |
| cmd_read | input | 1 | 1 = read cycle, 0 = write cycle |
| nibble_mode | input | 1 | 4-bit bus mode |
| pd_in | input | 8 | Bus value from the panel |
| pd_out | output | 8 | Bus value to the panel |
| pd_oe | output | 1 | Bus output enable (0 = released) |
| e_out | output | 1 | Panel strobe E |
| busy | output | 1 | Cycle in progress |
| rd_data | output | 8 | Captured read byte |

## Verification
The assertions assume that `if_en`, `cmd_go` and the control fields change only between clock edges and are stable at each rising edge. They also assume that reset is held for several cycles before the first command. The bench drives every input on falling edges, holds `cmd_go` and `cfg_we` for one edge at a time, and applies `pd_in` before a read cycle starts, so the captured value is well defined. Commands presented during a cycle are deliberately mixed in. The assertions treat these as legal input and expect them to be dropped.

// File: rtl/spanel_pkg.sv
package spanel_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int NIB_W  = DATA_W / 2;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic {CYC_WRITE = 1'b0, CYC_READ = 1'b1} cyc_kind_e;

  typedef struct packed {
    data_t data;
    cnt_t  preload;
    cnt_t  start;
  } ctl_word_t;

  // The strobe can only open when the threshold lies strictly below the preload.
  function automatic logic window_open(cnt_t start, cnt_t preload);
    return start < preload;
  endfunction

  function automatic logic last_count(cnt_t c);
    return c == '0;
  endfunction

  function automatic cnt_t next_count(cnt_t c);
    return c - cnt_t'(1);
  endfunction

  function automatic logic strobe_on(cnt_t c, cnt_t start, cnt_t preload);
    return window_open(start, preload) && !last_count(c) && (c <= start);
  endfunction

  function automatic data_t pin_map(data_t d, logic nib);
    data_t r;
    r = d;
    if (nib) r[DATA_W-1:NIB_W] = '0;
    return r;
  endfunction
endpackage

// File: rtl/spanel_fields.sv
module spanel_fields
  import spanel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  logic      busy,
  input  ctl_word_t cfg_in,
  output ctl_word_t ctl_q
);
  logic take;
  assign take = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= '0;
    else if (take) ctl_q <= cfg_in;
  end
endmodule

// File: rtl/spanel_pacer.sv
module spanel_pacer
  import spanel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      go_read,
  input  cnt_t      preload,
  output cnt_t      cnt_q,
  output logic      busy,
  output cyc_kind_e kind_q,
  output logic      zero_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy   <= 1'b0;
      kind_q <= CYC_WRITE;
    end else if (busy) begin
      if (last_count(cnt_q)) busy  <= 1'b0;
      else                   cnt_q <= next_count(cnt_q);
    end else if (go) begin
      cnt_q  <= preload;
      busy   <= 1'b1;
      kind_q <= go_read ? CYC_READ : CYC_WRITE;
    end
  end

  assign zero_cnt = busy && last_count(cnt_q);
endmodule

// File: rtl/spanel_strobe_gen.sv
module spanel_strobe_gen
  import spanel_pkg::*;
(
  input  logic busy,
  input  cnt_t cnt_q,
  input  cnt_t start,
  input  cnt_t preload,
  output logic e_out,
  output logic window_ok
);
  assign window_ok = window_open(start, preload);
  assign e_out     = busy && strobe_on(cnt_q, start, preload);
endmodule

// File: rtl/spanel_bus.sv
module spanel_bus
  import spanel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  data_t     data_q,
  input  logic      nibble_mode,
  input  logic      busy,
  input  cyc_kind_e kind_q,
  input  logic      zero_cnt,
  input  data_t     pd_in,
  output data_t     pd_out,
  output logic      pd_oe,
  output data_t     rd_data
);
  logic reading;
  assign reading = busy && (kind_q == CYC_READ);
  assign pd_out  = pin_map(data_q, nibble_mode);
  assign pd_oe   = !reading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rd_data <= '0;
    else if (reading && zero_cnt) rd_data <= pd_in;
  end
endmodule

// File: rtl/spanel_strobe.sv
module spanel_strobe
  import spanel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       cfg_we,
  input  logic [7:0] cfg_data,
  input  logic [7:0] cfg_preload,
  input  logic [7:0] cfg_start,
  input  logic       cmd_go,
  input  logic       cmd_read,
  input  logic       nibble_mode,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  output logic       e_out,
  output logic       busy,
  output logic [7:0] rd_data
);
  ctl_word_t cfg_in, ctl_q;
  cnt_t      cnt_q;
  cyc_kind_e kind_q;
  logic      zero_cnt, window_ok, go;

  assign cfg_in = '{data: cfg_data, preload: cfg_preload, start: cfg_start};
  assign go     = cmd_go && if_en && !busy;

  spanel_fields u_fields (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .busy(busy),
    .cfg_in(cfg_in), .ctl_q(ctl_q)
  );

  spanel_pacer u_pacer (
    .clk(clk), .rst_n(rst_n), .go(go), .go_read(cmd_read),
    .preload(ctl_q.preload), .cnt_q(cnt_q), .busy(busy),
    .kind_q(kind_q), .zero_cnt(zero_cnt)
  );

  spanel_strobe_gen u_strobe (
    .busy(busy), .cnt_q(cnt_q), .start(ctl_q.start),
    .preload(ctl_q.preload), .e_out(e_out), .window_ok(window_ok)
  );

  spanel_bus u_bus (
    .clk(clk), .rst_n(rst_n), .data_q(ctl_q.data), .nibble_mode(nibble_mode),
    .busy(busy), .kind_q(kind_q), .zero_cnt(zero_cnt), .pd_in(pd_in),
    .pd_out(pd_out), .pd_oe(pd_oe), .rd_data(rd_data)
  );
endmodule

// File: rtl/spanel_strobe_chk.sv
module spanel_strobe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_en,
  input logic       busy,
  input logic       e_out,
  input logic       pd_oe,
  input logic [7:0] data_q,
  input logic [7:0] cnt_q,
  input logic       zero_cnt,
  input logic       rd_cyc,
  input logic       window_ok
);
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !e_out);                                                     // R10
  AST_ZERO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt |-> !e_out);                                                  // R4
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !if_en) |=> !busy);                                          // R2
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !zero_cnt) |=> (busy && cnt_q == $past(cnt_q) - 8'd1));      // R3
  AST_ZERO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt |=> !busy);                                                   // R3
  AST_NO_GAP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !window_ok) |-> !e_out);                                      // R5
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_cyc) |-> !pd_oe);                                          // R7
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_cyc) |-> pd_oe);                                          // R6
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !zero_cnt) |=> $stable(data_q));                              // R8
endmodule

bind spanel_strobe spanel_strobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .busy(busy), .e_out(e_out),
  .pd_oe(pd_oe), .data_q(ctl_q.data), .cnt_q(cnt_q), .zero_cnt(zero_cnt),
  .rd_cyc(kind_q == spanel_pkg::CYC_READ), .window_ok(window_ok)
);

// File: tb/spanel_strobe_test.sv
`timescale 1ns/1ps
module spanel_strobe_test;
  logic clk = 0, rst_n = 0, if_en = 0, cfg_we = 0, cmd_go = 0, cmd_read = 0, nibble_mode = 0;
  logic [7:0] cfg_data = 0, cfg_preload = 0, cfg_start = 0, pd_in = 0;
  logic [7:0] pd_out, rd_data;
  logic pd_oe, e_out, busy;
  int checks = 0, errors = 0;
  bit cmp_en = 0;

  // Reference model state
  int m_busy = 0, m_cnt = 0, m_rd = 0, m_d = 0, m_p = 0, m_s = 0, m_rdd = 0;

  always #5 clk = ~clk;

  spanel_strobe uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_rd = 0; m_d = 0; m_p = 0; m_s = 0; m_rdd = 0;
    end else if (m_busy != 0) begin
      if (m_cnt == 0) begin
        m_busy = 0;
        if (m_rd != 0) m_rdd = int'(pd_in);
      end else m_cnt = m_cnt - 1;
    end else begin
      if (cmd_go && if_en) begin m_busy = 1; m_cnt = m_p; m_rd = int'(cmd_read); end
      if (cfg_we) begin m_d = int'(cfg_data); m_p = int'(cfg_preload); m_s = int'(cfg_start); end
    end
    #3;
    if (cmp_en && rst_n) begin
      check("R3 busy", int'(busy), m_busy);
      check("R4 e_out", int'(e_out),
            (m_busy != 0 && m_cnt != 0 && m_cnt <= m_s && m_s < m_p) ? 1 : 0);
      check("R6/R7 pd_oe", int'(pd_oe), (m_busy != 0 && m_rd != 0) ? 0 : 1);
      check("R9/R10 pd_out", int'(pd_out), nibble_mode ? (m_d & 15) : m_d);
      check("R7 rd_data", int'(rd_data), m_rdd);
    end
  end

  task automatic set_cfg(input int d, input int p, input int s);
    @(negedge clk);
    cfg_we = 1; cfg_data = 8'(d); cfg_preload = 8'(p); cfg_start = 8'(s);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_cyc(input bit rd, output int nb, output int ne);
    @(negedge clk); cmd_go = 1; cmd_read = rd;
    @(posedge clk); #3; cmd_go = 0; nb = 0; ne = 0;
    while (busy && nb < 1000) begin
      nb++;
      if (e_out) ne++;
      @(posedge clk); #3;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nb, ne;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 e_out", int'(e_out), 0);
    check("R1 pd_out", int'(pd_out), 0);
    check("R1 pd_oe", int'(pd_oe), 1);
    check("R1 rd_data", int'(rd_data), 0);
    rst_n = 1; cmp_en = 1;

    set_cfg(8'h11, 3, 1);
    run_cyc(0, nb, ne);
    check("R2 no start when disabled", nb, 0);
    if_en = 1;

    set_cfg(8'hA5, 6, 3);
    run_cyc(0, nb, ne);
    check("R3 busy length", nb, 7);
    check("R4 strobe length", ne, 3);
    check("R10 pd_out holds", int'(pd_out), 8'hA5);

    set_cfg(8'hA5, 4, 4);
    run_cyc(0, nb, ne);
    check("R5 S==P no strobe", ne, 0);
    set_cfg(8'hA5, 4, 9);
    run_cyc(0, nb, ne);
    check("R5 S>P no strobe", ne, 0);
    set_cfg(8'hA5, 5, 0);
    run_cyc(0, nb, ne);
    check("R4 S=0 no strobe", ne, 0);
    set_cfg(8'hA5, 0, 0);
    run_cyc(0, nb, ne);
    check("R3 preload 0 length", nb, 1);
    set_cfg(8'h3C, 255, 254);
    run_cyc(0, nb, ne);
    check("R3 max preload length", nb, 256);
    check("R4 max strobe length", ne, 254);

    pd_in = 8'hC3;
    set_cfg(8'h3C, 5, 2);
    run_cyc(1, nb, ne);
    check("R7 read length", nb, 6);
    check("R7 read strobe", ne, 2);
    check("R7 captured", int'(rd_data), 8'hC3);
    check("R6 pins driven after read", int'(pd_oe), 1);

    set_cfg(8'h5A, 10, 4);
    @(negedge clk); cmd_go = 1; cmd_read = 0;
    @(negedge clk); cmd_go = 0;
    repeat (3) @(negedge clk);
    cfg_we = 1; cfg_data = 8'hFF; cfg_preload = 8'd2; cfg_start = 8'd1; cmd_go = 1;
    @(negedge clk); cfg_we = 0; cmd_go = 0;
    while (busy) @(negedge clk);
    check("R8 data kept", int'(pd_out), 8'h5A);
    run_cyc(0, nb, ne);
    check("R8 preload kept", nb, 11);
    check("R8 threshold kept", ne, 4);

    @(negedge clk); nibble_mode = 1;
    @(negedge clk);
    check("R9 nibble pins", int'(pd_out), 8'h0A);
    run_cyc(0, nb, ne);
    check("R9 nibble cycle length", nb, 11);
    @(negedge clk); nibble_mode = 0;
    @(negedge clk);
    check("R9 full pins", int'(pd_out), 8'h5A);
    check("R10 idle strobe low", int'(e_out), 0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule